// File: doc/BRIEF.md
# Float-to-Integer Range-Checking Converter

This block turns an IEEE-754 single- or double-precision operand into a signed 32-bit or 64-bit integer. It sits beside a floating-point datapath. The caller presents an operand together with a precision select, a result-width select, an operation code and a 2-bit rounding mode. One clock later the block returns either a valid integer or a cause strobe. The operations are a generic convert, which rounds according to the mode input, and four conversions with a fixed rule: round-to-nearest, truncate, ceiling and floor.

The block does not saturate. It does not report "invalid" for operands it cannot handle. NaN, infinity, denormal and out-of-range sources all raise an "unimplemented" cause instead, and each precision has its own magnitude limit. A separate operation applies only the range test for the integer-to-float direction to a 64-bit integer source. Status-register storage and exception dispatch belong to the surrounding unit.

Top module: `fp_to_int_conv`

## Requirements
- R1: For the generic convert (op code 0), `rnd_mode` selects the rounding: 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R2: Op codes 1 (nearest-even), 2 (toward zero), 3 (toward +infinity) and 4 (toward -infinity) use their fixed rule and ignore `rnd_mode`.
- R3: A NaN, infinite or denormal source raises `cause_unimpl`. A zero of either sign returns a valid result of 0 and raises no cause.
- R4: A single-precision source (low word of `src`, `src_dbl` = 0) whose magnitude is 2^31 or more raises `cause_unimpl`. This includes exactly -2^31.
- R5: A double-precision source (`src_dbl` = 1) whose magnitude is 2^53 or more raises `cause_unimpl`.
- R6: With a 32-bit result (`res_long` = 0), a rounded value outside [-2^31, 2^31-1] raises `cause_unimpl`.
- R7: `cause_inexact` rises when the returned integer differs from the source value. It never rises together with `cause_unimpl`.
- R8: Whenever `cause_unimpl` is high, `res_valid` is low and `res` is zero.
- R9: A 32-bit result appears sign-extended across all 64 bits of `res`.
- R10: Op code 5 treats `src` as a signed 64-bit integer. A value of 2^55 or more, or below -2^55, raises `cause_unimpl`. Any other value is returned unchanged with `res_valid` high.
- R11: Outputs are registered with a latency of one cycle. In a cycle after `op_valid` was low, every output is zero. Reset clears all outputs.
- R12: Reserved op codes 6 and 7 raise `cause_unimpl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_code | input | 3 | 0 convert, 1 nearest, 2 truncate, 3 ceiling, 4 floor, 5 64-bit integer range check |
| src_dbl | input | 1 | 1 = double source, 0 = single source in bits 31:0 |
| res_long | input | 1 | 1 = 64-bit result, 0 = 32-bit result |
| rnd_mode | input | 2 | Rounding mode for op code 0 |
| src | input | 64 | Operand bits |
| res_valid | output | 1 | Integer result valid |
| res | output | 64 | Integer result |
| cause_inexact | output | 1 | Result differs from the source value |
| cause_unimpl | output | 1 | Operand not handled by the hardware |

## Verification
On every cycle, assertions enforce the following: the unimplemented strobe always comes with an empty, invalid result, and the two causes are mutually exclusive. Outputs stay quiet after an idle cycle. A special operand always ends as unimplemented, and 32-bit results are sign-extended. The 64-bit range check is also covered this way. Only the bench's scenarios can show correct numeric rounding: ties to even, the asymmetric edges at exactly ±2^31 and 2^53, and the fact that fixed-rule operations ignore the mode input. The bench compares every result against a reference built on real arithmetic.

// File: rtl/fpi_pkg.sv
package fpi_pkg;

    typedef enum logic [2:0] {
        OP_CVT  = 3'd0,
        OP_RND  = 3'd1,
        OP_TRN  = 3'd2,
        OP_CEIL = 3'd3,
        OP_FLR  = 3'd4,
        OP_LCHK = 3'd5
    } fpi_op_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_PINF = 2'd2,
        RM_NINF = 2'd3
    } fpi_rmode_e;

    localparam int SIG_W = 53;   // hidden bit + double fraction
    localparam int EXP_W = 13;   // signed unbiased exponent
    localparam int SH_W  = 6;    // shift amount up to 54

    typedef struct packed {
        logic        valid;
        logic [63:0] res;
        logic        inexact;
        logic        unimpl;
    } fpi_out_t;

endpackage

// File: rtl/fpi_unpack.sv
module fpi_unpack
    import fpi_pkg::*;
#(
    parameter int SGL_LIMIT_EXP = 31,
    parameter int DBL_LIMIT_EXP = 53
) (
    input  logic                    dbl_i,
    input  logic [63:0]             bits_i,
    output logic                    sign_o,
    output logic signed [EXP_W-1:0] exp_o,
    output logic [SIG_W-1:0]        sig_o,
    output logic                    zero_o,
    output logic                    special_o,
    output logic                    big_o
);

    logic        frac_nz;
    logic        exp_max;
    logic        exp_min;

    always_comb begin
        if (dbl_i) begin
            sign_o  = bits_i[63];
            exp_o   = $signed({2'b00, bits_i[62:52]}) - 13'sd1023;
            sig_o   = {1'b1, bits_i[51:0]};
            frac_nz = |bits_i[51:0];
            exp_max = &bits_i[62:52];
            exp_min = ~|bits_i[62:52];
        end else begin
            sign_o  = bits_i[31];
            exp_o   = $signed({5'b00000, bits_i[30:23]}) - 13'sd127;
            sig_o   = {1'b1, bits_i[22:0], 29'b0};
            frac_nz = |bits_i[22:0];
            exp_max = &bits_i[30:23];
            exp_min = ~|bits_i[30:23];
        end
        zero_o    = exp_min && !frac_nz;
        special_o = exp_max || (exp_min && frac_nz);
        if (dbl_i)
            big_o = !zero_o && !special_o && (exp_o >= 13'(DBL_LIMIT_EXP));
        else
            big_o = !zero_o && !special_o && (exp_o >= 13'(SGL_LIMIT_EXP));
    end

endmodule

// File: rtl/fpi_round.sv
module fpi_round
    import fpi_pkg::*;
(
    input  logic                    sign_i,
    input  logic signed [EXP_W-1:0] exp_i,
    input  logic [SIG_W-1:0]        sig_i,
    input  fpi_rmode_e              mode_i,
    output logic [63:0]             mag_o,
    output logic                    inexact_o
);

    logic [SH_W-1:0] sh;
    logic [63:0]     sig64;
    logic [63:0]     low_mask;
    logic [63:0]     half_mask;
    logic [63:0]     frac;
    logic [63:0]     ipart;
    logic            half;
    logic            sticky;
    logic            inc;

    always_comb begin
        if (exp_i > 13'sd52)
            sh = '0;
        else if (exp_i < -13'sd1)
            sh = 6'd54;
        else
            sh = SH_W'(13'sd52 - exp_i);

        sig64     = {11'b0, sig_i};
        low_mask  = (64'd1 << sh) - 64'd1;
        half_mask = (sh != '0) ? (64'd1 << (sh - 6'd1)) : 64'd0;
        frac      = sig64 & low_mask;
        ipart     = sig64 >> sh;
        half      = |(frac & half_mask);
        sticky    = |(frac & ~half_mask);
        inexact_o = |frac;

        unique case (mode_i)
            RM_NEAR: inc = half && (sticky || ipart[0]);
            RM_ZERO: inc = 1'b0;
            RM_PINF: inc = inexact_o && !sign_i;
            RM_NINF: inc = inexact_o && sign_i;
            default: inc = 1'b0;
        endcase
        mag_o = ipart + {63'b0, inc};
    end

endmodule

// File: rtl/fpi_sign.sv
module fpi_sign (
    input  logic        sign_i,
    input  logic        long_i,
    input  logic [63:0] mag_i,
    output logic [63:0] val_o,
    output logic        fits_word_o
);

    logic [63:0] full;

    always_comb begin
        full        = sign_i ? (~mag_i + 64'd1) : mag_i;
        fits_word_o = sign_i ? (mag_i <= 64'h0000_0000_8000_0000)
                             : (mag_i <= 64'h0000_0000_7FFF_FFFF);
        val_o       = long_i ? full : {{32{full[31]}}, full[31:0]};
    end

endmodule

// File: rtl/fp_to_int_conv.sv
module fp_to_int_conv
    import fpi_pkg::*;
#(
    parameter int SGL_LIMIT_EXP  = 31,
    parameter int DBL_LIMIT_EXP  = 53,
    parameter int LCHK_LIMIT_EXP = 55
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [2:0]  op_code,
    input  logic        src_dbl,
    input  logic        res_long,
    input  logic [1:0]  rnd_mode,
    input  logic [63:0] src,
    output logic        res_valid,
    output logic [63:0] res,
    output logic        cause_inexact,
    output logic        cause_unimpl
);

    localparam logic signed [63:0] LCHK_HI = 64'sd1 <<< LCHK_LIMIT_EXP;
    localparam logic signed [63:0] LCHK_LO = -LCHK_HI;

    fpi_out_t state_d, state_q;

    logic                    u_sign;
    logic signed [EXP_W-1:0] u_exp;
    logic [SIG_W-1:0]        u_sig;
    logic                    u_zero;
    logic                    u_special;
    logic                    u_big;
    fpi_rmode_e              eff_mode;
    logic [63:0]             mag;
    logic                    rnd_inexact;
    logic [63:0]             signed_val;
    logic                    fits_word;
    logic                    lchk_out;

    fpi_unpack #(
        .SGL_LIMIT_EXP (SGL_LIMIT_EXP),
        .DBL_LIMIT_EXP (DBL_LIMIT_EXP)
    ) u_unpack (
        .dbl_i     (src_dbl),
        .bits_i    (src),
        .sign_o    (u_sign),
        .exp_o     (u_exp),
        .sig_o     (u_sig),
        .zero_o    (u_zero),
        .special_o (u_special),
        .big_o     (u_big)
    );

    always_comb begin
        unique case (op_code)
            OP_RND:  eff_mode = RM_NEAR;
            OP_TRN:  eff_mode = RM_ZERO;
            OP_CEIL: eff_mode = RM_PINF;
            OP_FLR:  eff_mode = RM_NINF;
            default: eff_mode = fpi_rmode_e'(rnd_mode);
        endcase
    end

    fpi_round u_round (
        .sign_i    (u_sign),
        .exp_i     (u_exp),
        .sig_i     (u_sig),
        .mode_i    (eff_mode),
        .mag_o     (mag),
        .inexact_o (rnd_inexact)
    );

    fpi_sign u_sign_stage (
        .sign_i      (u_sign),
        .long_i      (res_long),
        .mag_i       (mag),
        .val_o       (signed_val),
        .fits_word_o (fits_word)
    );

    assign lchk_out = ($signed(src) >= LCHK_HI) || ($signed(src) < LCHK_LO);

    always_comb begin
        state_d = '0;
        if (op_valid) begin
            unique case (op_code)
                OP_CVT, OP_RND, OP_TRN, OP_CEIL, OP_FLR: begin
                    if (u_special || u_big) begin
                        state_d.unimpl = 1'b1;
                    end else if (u_zero) begin
                        state_d.valid = 1'b1;
                    end else if (!res_long && !fits_word) begin
                        state_d.unimpl = 1'b1;
                    end else begin
                        state_d.valid   = 1'b1;
                        state_d.res     = signed_val;
                        state_d.inexact = rnd_inexact;
                    end
                end
                OP_LCHK: begin
                    if (lchk_out) begin
                        state_d.unimpl = 1'b1;
                    end else begin
                        state_d.valid = 1'b1;
                        state_d.res   = src;
                    end
                end
                default: state_d.unimpl = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign res_valid     = state_q.valid;
    assign res           = state_q.res;
    assign cause_inexact = state_q.inexact;
    assign cause_unimpl  = state_q.unimpl;

    AST_UNIMPL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        cause_unimpl |-> (!res_valid && res == 64'd0)); // R8

    AST_CAUSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cause_unimpl && cause_inexact)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !cause_unimpl && !cause_inexact)); // R11

    AST_WORD_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !res_long && op_code <= 3'd4) |=>
            (!res_valid || res[63:32] == {32{res[31]}})); // R9

    AST_SPECIAL_UNIMPL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code <= 3'd4 && u_special) |=> cause_unimpl); // R3

    AST_LCHK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd5) |=>
            (cause_unimpl == !((&$past(src[63:LCHK_LIMIT_EXP])) ||
                               !(|$past(src[63:LCHK_LIMIT_EXP]))))); // R10

    AST_RESERVED_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code[2] && op_code[1]) |=> cause_unimpl); // R12

endmodule

// File: tb/fp_to_int_conv_bench.sv
`timescale 1ns/1ps
module fp_to_int_conv_bench;

    typedef struct packed {
        logic        valid;
        logic [63:0] res;
        logic        inexact;
        logic        unimpl;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic        src_dbl = 1'b0;
    logic        res_long = 1'b0;
    logic [1:0]  rnd_mode = '0;
    logic [63:0] src = '0;
    logic        res_valid;
    logic [63:0] res;
    logic        cause_inexact;
    logic        cause_unimpl;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fp_to_int_conv u_fp_to_int_conv (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_valid      (op_valid),
        .op_code       (op_code),
        .src_dbl       (src_dbl),
        .res_long      (res_long),
        .rnd_mode      (rnd_mode),
        .src           (src),
        .res_valid     (res_valid),
        .res           (res),
        .cause_inexact (cause_inexact),
        .cause_unimpl  (cause_unimpl)
    );

    function automatic exp_t model(logic [2:0] op, logic dbl, logic lng,
                                   logic [1:0] md, logic [63:0] s);
        exp_t        e;
        logic [10:0] be;
        logic [51:0] m;
        logic [63:0] db;
        logic [1:0]  eff;
        real         v, fr, afr, lim;
        longint      t, r;
        e = '0;
        if (op == 3'd5) begin
            if ($signed(s) >= 64'sh0080_0000_0000_0000 ||
                $signed(s) < -64'sh0080_0000_0000_0000) e.unimpl = 1'b1;
            else begin e.valid = 1'b1; e.res = s; end
            return e;
        end
        if (op > 3'd5) begin e.unimpl = 1'b1; return e; end
        if (dbl) begin
            be = s[62:52]; m = s[51:0]; db = s;
        end else begin
            if (s[30:23] == 8'hFF)      be = 11'h7FF;
            else if (s[30:23] == 8'h00) be = 11'h000;
            else                        be = {3'b000, s[30:23]} + 11'd896;
            m  = {s[22:0], 29'b0};
            db = {s[31], be, m};
        end
        if (be == 11'h7FF || (be == 11'h000 && m != 52'd0)) begin
            e.unimpl = 1'b1; return e;
        end
        if (be == 11'h000) begin e.valid = 1'b1; return e; end
        v   = $bitstoreal(db);
        lim = dbl ? 9007199254740992.0 : 2147483648.0;
        if (v >= lim || v <= -lim) begin e.unimpl = 1'b1; return e; end
        case (op)
            3'd0: eff = md;
            3'd1: eff = 2'd0;
            3'd2: eff = 2'd1;
            3'd3: eff = 2'd2;
            default: eff = 2'd3;
        endcase
        t = longint'(v);
        if (v >= 0.0 && real'(t) > v) t = t - 1;
        if (v < 0.0 && real'(t) < v)  t = t + 1;
        fr = v - real'(t);
        r  = t;
        case (eff)
            2'd2: if (fr > 0.0) r = t + 1;
            2'd3: if (fr < 0.0) r = t - 1;
            2'd0: begin
                afr = (fr < 0.0) ? -fr : fr;
                if (afr > 0.5 || (afr == 0.5 && t[0])) r = (fr > 0.0) ? t + 1 : t - 1;
            end
            default: r = t;
        endcase
        if (!lng && (r > 64'sd2147483647 || r < -64'sd2147483648)) begin
            e.unimpl = 1'b1; return e;
        end
        e.valid   = 1'b1;
        e.res     = r;
        e.inexact = (fr != 0.0);
        return e;
    endfunction

    task automatic compare(input exp_t ex, input string tag);
        checks++;
        if (res_valid !== ex.valid || res !== ex.res ||
            cause_inexact !== ex.inexact || cause_unimpl !== ex.unimpl) begin
            errors++;
            $display("FAIL %s: got v=%0b res=%h inx=%0b unimp=%0b expected v=%0b res=%h inx=%0b unimp=%0b",
                     tag, res_valid, res, cause_inexact, cause_unimpl,
                     ex.valid, ex.res, ex.inexact, ex.unimpl);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic dbl, input logic lng,
                       input logic [1:0] md, input logic [63:0] s, input string tag);
        exp_t ex;
        ex       = model(op, dbl, lng, md, s);
        op_valid = 1'b1;
        op_code  = op;
        src_dbl  = dbl;
        res_long = lng;
        rnd_mode = md;
        src      = s;
        @(negedge clk);
        compare(ex, tag);
        op_valid = 1'b0;
    endtask

    task automatic idle_check(input logic [63:0] junk, input string tag);
        op_valid = 1'b0;
        op_code  = 3'd0;
        src      = junk;
        @(negedge clk);
        compare('0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [2:0]  op;
        logic        dbl, lng;
        logic [63:0] s;
        string       tag;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare('0, "R11 reset");

        // R1: mode input on the generic convert, with single 2.5, -2.5 and 3.5
        for (int md = 0; md < 4; md++) begin
            run(3'd0, 1'b0, 1'b0, 2'(md), 64'h4020_0000, "R1");
            run(3'd0, 1'b0, 1'b0, 2'(md), 64'hC020_0000, "R1");
            run(3'd0, 1'b0, 1'b1, 2'(md), 64'h4060_0000, "R1");
        end
        // R2: fixed-rule operations ignore the mode input
        run(3'd1, 1'b0, 1'b0, 2'd3, 64'h4020_0000, "R2");
        run(3'd2, 1'b0, 1'b0, 2'd2, 64'h4020_0000, "R2");
        run(3'd3, 1'b0, 1'b0, 2'd0, 64'h4020_0000, "R2");
        run(3'd4, 1'b0, 1'b0, 2'd2, 64'hC020_0000, "R2");
        // R3: NaN, infinity, denormal, negative zero
        run(3'd0, 1'b0, 1'b0, 2'd0, 64'h7FC0_0000, "R3");
        run(3'd2, 1'b0, 1'b0, 2'd0, 64'hFF80_0000, "R3");
        run(3'd2, 1'b0, 1'b1, 2'd0, 64'h0000_0001, "R3");
        run(3'd2, 1'b1, 1'b1, 2'd0, 64'h000F_0000_0000_0000, "R3");
        run(3'd0, 1'b0, 1'b0, 2'd0, 64'h8000_0000, "R3");
        // R4: single range edges
        run(3'd2, 1'b0, 1'b1, 2'd0, 64'h4F00_0000, "R4");
        run(3'd2, 1'b0, 1'b1, 2'd0, 64'hCF00_0000, "R4");
        run(3'd2, 1'b0, 1'b0, 2'd0, 64'h4EFF_FFFF, "R4");
        // R5: double range edges
        run(3'd2, 1'b1, 1'b1, 2'd0, $realtobits(9007199254740992.0), "R5");
        run(3'd2, 1'b1, 1'b1, 2'd0, $realtobits(-9007199254740992.0), "R5");
        run(3'd2, 1'b1, 1'b1, 2'd0, 64'h433F_FFFF_FFFF_FFFF, "R5");
        // R6: word result range
        run(3'd2, 1'b1, 1'b0, 2'd0, $realtobits(2147483648.0), "R6");
        run(3'd2, 1'b1, 1'b1, 2'd0, $realtobits(2147483648.0), "R6");
        run(3'd0, 1'b1, 1'b0, 2'd2, $realtobits(2147483647.5), "R6");
        run(3'd0, 1'b1, 1'b0, 2'd1, $realtobits(2147483647.5), "R6");
        // R7: exact and inexact results
        run(3'd0, 1'b1, 1'b1, 2'd0, $realtobits(5.0), "R7");
        run(3'd3, 1'b1, 1'b1, 2'd0, $realtobits(0.25), "R7");
        // R8: unimplemented yields an empty result
        run(3'd1, 1'b1, 1'b1, 2'd0, 64'h7FF8_0000_0000_0000, "R8");
        // R9: sign extension of word results
        run(3'd2, 1'b1, 1'b0, 2'd0, $realtobits(-2147483648.0), "R9");
        run(3'd2, 1'b0, 1'b0, 2'd0, 64'hBF80_0000, "R9");
        // R10: 64-bit integer range check
        run(3'd5, 1'b0, 1'b0, 2'd0, 64'h007F_FFFF_FFFF_FFFF, "R10");
        run(3'd5, 1'b0, 1'b0, 2'd0, 64'h0080_0000_0000_0000, "R10");
        run(3'd5, 1'b0, 1'b0, 2'd0, 64'hFF80_0000_0000_0000, "R10");
        run(3'd5, 1'b0, 1'b0, 2'd0, 64'hFF7F_FFFF_FFFF_FFFF, "R10");
        // R11: idle cycle with junk inputs
        idle_check(64'h7FF8_0000_0000_0001, "R11 idle");
        // R12: reserved codes
        run(3'd6, 1'b0, 1'b0, 2'd0, 64'h4020_0000, "R12");
        run(3'd7, 1'b1, 1'b1, 2'd0, $realtobits(1.0), "R12");

        for (int i = 0; i < 4000; i++) begin
            op  = 3'($urandom % 8);
            dbl = 1'($urandom);
            lng = 1'($urandom);
            if (op == 3'd5) begin
                s = {$urandom, $urandom} >>> ($urandom % 16);
                if ($urandom % 2 == 0) s = s | 64'hFF00_0000_0000_0000;
            end else if (dbl) begin
                s[63]    = 1'($urandom);
                s[62:52] = 11'(990 + $urandom % 90);
                if ($urandom % 20 == 0) s[62:52] = ($urandom % 2 == 0) ? 11'h7FF : 11'h000;
                s[51:0]  = 52'({$urandom, $urandom}) & (52'hF_FFFF_FFFF_FFFF << ($urandom % 53));
            end else begin
                s[63:32] = $urandom;
                s[31]    = 1'($urandom);
                s[30:23] = 8'(100 + $urandom % 65);
                if ($urandom % 20 == 0) s[30:23] = ($urandom % 2 == 0) ? 8'hFF : 8'h00;
                s[22:0]  = 23'($urandom) & (23'h7F_FFFF << ($urandom % 24));
            end
            if (op == 3'd5)      tag = "R10";
            else if (op > 3'd5)  tag = "R12";
            else if (op == 3'd0) tag = "R1";
            else                 tag = "R2";
            run(op, dbl, lng, 2'($urandom), s, tag);
            if (i % 500 == 0) idle_check(s, "R11");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule